// File: doc/BRIEF.md
# GPIO Input Qualification Filter

This block cleans up a group of general-purpose input pins before the rest of the chip sees them. Every pin goes through a two-stage synchronizer into the system clock domain. Each pin can then either forward the synchronized level directly or pass it through a glitch qualifier. The qualifier keeps a short history of periodic samples and changes the pin's output only when every sample in the chosen window agrees on a new level.

All pins of the group share one sampling strobe. That strobe comes from an 8-bit period value. A period of zero samples on every clock. A non-zero value n samples once every 2·n clocks. Software-side logic sets up the block through a small write-only register port. One address holds the period and the other holds the per-pin mode fields.

Top module: `gpio_qual_filter`

## Requirements
- R1: Each pin input goes through two synchronizer flops. In pass-through mode, the pin output equals the pin input delayed by exactly three clock edges. After reset every pin is in this mode.
- R2: With period 0, a sample is taken on every clock. In 3-sample mode, an input level change shows at the output six edges after it is applied. A pulse of 2 cycles is ignored and a pulse of 3 cycles is accepted.
- R3: With a non-zero period n, a sample is taken once every 2·n clocks. With n=2 in 3-sample mode, a 7-cycle pulse is ignored. With n=1 in 6-sample mode, a 9-cycle pulse is ignored. A level held for 30 or more cycles is accepted.
- R4: A write to the period address restarts the prescaler. The first strobe after the write comes 2·n clocks after the write edge. With n=0xFF, 3-sample mode and the input raised just after the write, the output is still 0 after 1530 edges and is 1 after 1531 edges.
- R5: Each pin has its own 2-bit mode field at bits [2i+1:2i] of the mode register. The encodings are 00 pass-through, 01 3-sample, 10 6-sample and 11 6-sample. Pins in different modes respond to the same 4-cycle pulse independently.
- R6: In 6-sample mode with period 0, a level change shows at the output nine edges after it is applied. A 5-cycle pulse is ignored and a 6-cycle pulse is accepted.
- R7: In a qualifying mode, the output holds its previous level for as long as the samples in the window disagree.
- R8: Synchronous active-high reset clears every output, every sample history and the period, and sets every pin to pass-through.
- R9: The register port writes on `cfg_wr`. `cfg_sel`=0 selects the period, taken from `cfg_wdata[7:0]`. `cfg_sel`=1 selects the mode word, taken from `cfg_wdata[15:0]`. A write to one address leaves the other unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_in | input | NPINS | Raw asynchronous pin levels |
| cfg_wr | input | 1 | Register write strobe |
| cfg_sel | input | 1 | Register select: 0 period, 1 mode word |
| cfg_wdata | input | CFG_W | Register write data |
| pin_out | output | NPINS | Qualified pin levels |

## Verification
The bench builds the block with the default eight pins and an 8-bit period. These defaults make all four mode codes and the full period range available. Period values 0, 1, 2, 0x40 and 0xFF are used. With these values, the exact edge latencies of the 3-sample and 6-sample windows can be checked, as can the one-cycle margin between rejected and accepted pulses and the prescaler restart at the longest period. Giving a different mode to each pin pair shows that the per-pin fields are decoded independently.

// File: rtl/gpio_qual_pkg.sv
package gpio_qual_pkg;

    typedef enum logic [1:0] {
        QM_SYNC     = 2'b00,
        QM_THREE    = 2'b01,
        QM_SIX      = 2'b10,
        QM_SIX_ALT  = 2'b11
    } qmode_e;

    localparam int HIST_W  = 6;
    localparam int SHORT_W = 3;

    typedef struct packed {
        logic [HIST_W-1:0] hist;
        logic              q;
    } lane_st_t;

    function automatic logic is_six(qmode_e m);
        return m[1];
    endfunction

    function automatic logic window_agrees(logic [HIST_W-1:0] h, logic six);
        if (six)
            return (h == '0) || (h == '1);
        else
            return (h[SHORT_W-1:0] == '0) || (h[SHORT_W-1:0] == '1);
    endfunction

endpackage

// File: rtl/gpio_qual_tick.sv
module gpio_qual_tick #(
    parameter int PER_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [PER_W-1:0] period,
    input  logic             reload,
    output logic             tick
);
    localparam int CNT_W = PER_W + 1;

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] term;

    assign term = {period, 1'b0} - CNT_W'(1);
    assign tick = (period == '0) || (cnt == term);

    always_ff @(posedge clk) begin
        if (rst || reload)
            cnt <= '0;
        else if (tick)
            cnt <= '0;
        else
            cnt <= cnt + CNT_W'(1);
    end

    // R3: the count never runs past the end of a 2*n window
    p_cnt_bound_r3: assert property (@(posedge clk) disable iff (rst)
        (period != '0) |-> (cnt <= term));

    // R4: a restart never produces a strobe on the following cycle for n>0
    p_reload_gap_r4: assert property (@(posedge clk) disable iff (rst)
        reload |=> (!tick || period == '0));

endmodule

// File: rtl/gpio_qual_sync.sv
module gpio_qual_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end

    // R1: output is the input two edges earlier
    p_two_stage_r1: assert property (@(posedge clk) disable iff (rst)
        !$past(rst, 2) |-> (q == $past(d, 2)));

endmodule

// File: rtl/gpio_qual_lane.sv
module gpio_qual_lane
    import gpio_qual_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   tick,
    input  logic   din,
    input  qmode_e mode,
    output logic   q
);
    lane_st_t st;
    logic     agree;

    assign agree = window_agrees(st.hist, is_six(mode));
    assign q     = st.q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= '0;
        end else begin
            if (tick)
                st.hist <= {st.hist[HIST_W-2:0], din};
            if (mode == QM_SYNC)
                st.q <= din;
            else if (agree)
                st.q <= st.hist[0];
        end
    end

    // R1: pass-through mode forwards the synchronized level one edge later
    p_sync_follow_r1: assert property (@(posedge clk) disable iff (rst)
        (mode == QM_SYNC) |=> (q == $past(din)));

    // R3: history only moves on a strobe
    p_hist_still_r3: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(st.hist));

    // R7: 3-sample mode holds while its window is mixed
    p_hold_three_r7: assert property (@(posedge clk) disable iff (rst)
        (mode == QM_THREE && st.hist[2:0] != 3'b000 && st.hist[2:0] != 3'b111)
        |=> $stable(q));

    // R6: 6-sample mode holds while its window is mixed
    p_hold_six_r6: assert property (@(posedge clk) disable iff (rst)
        (mode[1] && st.hist != '0 && st.hist != '1) |=> $stable(q));

    // R8: reset clears output and history
    p_reset_clear_r8: assert property (@(posedge clk)
        rst |=> (q == 1'b0 && st.hist == '0));

endmodule

// File: rtl/gpio_qual_filter.sv
module gpio_qual_filter
    import gpio_qual_pkg::*;
#(
    parameter int NPINS = 8,
    parameter int PER_W = 8,
    parameter int CFG_W = (PER_W > 2*NPINS) ? PER_W : 2*NPINS
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NPINS-1:0] pin_in,
    input  logic             cfg_wr,
    input  logic             cfg_sel,
    input  logic [CFG_W-1:0] cfg_wdata,
    output logic [NPINS-1:0] pin_out
);
    localparam logic SEL_PERIOD = 1'b0;
    localparam logic SEL_MODE   = 1'b1;

    logic [PER_W-1:0] period_q;
    qmode_e           mode_q [NPINS];
    logic [NPINS-1:0] pin_sync;
    logic             tick;
    logic             per_wr;
    logic             mode_wr;

    assign per_wr  = cfg_wr && (cfg_sel == SEL_PERIOD);
    assign mode_wr = cfg_wr && (cfg_sel == SEL_MODE);

    always_ff @(posedge clk) begin
        if (rst)
            period_q <= '0;
        else if (per_wr)
            period_q <= cfg_wdata[PER_W-1:0];
    end

    gpio_qual_sync #(.W(NPINS)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pin_in),
        .q   (pin_sync)
    );

    gpio_qual_tick #(.PER_W(PER_W)) u_tick (
        .clk    (clk),
        .rst    (rst),
        .period (period_q),
        .reload (per_wr),
        .tick   (tick)
    );

    for (genvar i = 0; i < NPINS; i++) begin : g_lane
        always_ff @(posedge clk) begin
            if (rst)
                mode_q[i] <= QM_SYNC;
            else if (mode_wr)
                mode_q[i] <= qmode_e'(cfg_wdata[2*i +: 2]);
        end

        gpio_qual_lane u_lane (
            .clk  (clk),
            .rst  (rst),
            .tick (tick),
            .din  (pin_sync[i]),
            .mode (mode_q[i]),
            .q    (pin_out[i])
        );
    end

    // R9: a mode write leaves the period untouched
    p_sel_isolate_r9: assert property (@(posedge clk) disable iff (rst)
        mode_wr |=> $stable(period_q));

    // R8: reset returns period to zero and pin 0 to pass-through
    p_reset_cfg_r8: assert property (@(posedge clk)
        rst |=> (period_q == '0 && mode_q[0] == QM_SYNC && pin_out == '0));

endmodule

// File: tb/gpio_qual_filter_bench.sv
module gpio_qual_filter_bench;
    localparam int NP = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NP-1:0] pin_in = '0;
    logic          cfg_wr = 1'b0;
    logic          cfg_sel = 1'b0;
    logic [15:0]   cfg_wdata = '0;
    logic [NP-1:0] pin_out;

    int total = 0;
    int bad = 0;
    logic          mon = 1'b0;
    logic [NP-1:0] seen = '0;

    always #2 clk = ~clk;

    gpio_qual_filter u_gpio_qual_filter (
        .clk(clk), .rst(rst), .pin_in(pin_in), .cfg_wr(cfg_wr),
        .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .pin_out(pin_out)
    );

    always @(negedge clk) if (mon) seen = seen | pin_out;

    task automatic chk(string req, logic [NP-1:0] act, logic [NP-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic sel, logic [15:0] d);
        @(negedge clk); cfg_wr = 1'b1; cfg_sel = sel; cfg_wdata = d;
        @(negedge clk); cfg_wr = 1'b0;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_seen(string req, logic [NP-1:0] mask, int w, int tail,
                              logic [NP-1:0] exp);
        @(negedge clk); seen = '0; mon = 1'b1;
        pin_in = mask;
        idle(w);
        pin_in = '0;
        idle(tail);
        mon = 1'b0;
        chk(req, seen, exp);
    endtask

    task automatic t_reset;
        chk("R8 reset output", pin_out, 8'h00);
    endtask

    task automatic t_sync_follow;
        @(negedge clk); pin_in = 8'hA5;
        idle(2); chk("R1 before third edge", pin_out, 8'h00);
        idle(1); chk("R1 after third edge", pin_out, 8'hA5);
        pin_in = '0; idle(6);
    endtask

    task automatic t_three_latency;
        wr(1'b1, 16'h5555);
        idle(10);
        @(negedge clk); pin_in = 8'hFF;
        idle(5); chk("R2 R9 3-sample before edge 6", pin_out, 8'h00);
        idle(1); chk("R2 R9 3-sample at edge 6", pin_out, 8'hFF);
        pin_in = '0; idle(12);
    endtask

    task automatic t_three_glitch;
        pulse_seen("R2 R7 2-cycle pulse ignored", 8'hFF, 2, 15, 8'h00);
        pulse_seen("R2 3-cycle pulse accepted", 8'hFF, 3, 15, 8'hFF);
        chk("R2 returns low", pin_out, 8'h00);
    endtask

    task automatic t_six;
        wr(1'b1, 16'hAAAA);
        idle(10);
        @(negedge clk); pin_in = 8'hFF;
        idle(8); chk("R6 6-sample before edge 9", pin_out, 8'h00);
        idle(1); chk("R6 6-sample at edge 9", pin_out, 8'hFF);
        pin_in = '0; idle(15);
        pulse_seen("R6 R7 5-cycle pulse ignored", 8'hFF, 5, 15, 8'h00);
        pulse_seen("R6 6-cycle pulse accepted", 8'hFF, 6, 15, 8'hFF);
    endtask

    task automatic t_mixed;
        wr(1'b1, 16'hFA50);
        idle(10);
        pulse_seen("R5 per-pin modes", 8'hFF, 4, 15, 8'h0F);
    endtask

    task automatic t_period_two;
        wr(1'b1, 16'h5555);
        wr(1'b0, 16'h0002);
        idle(20);
        pulse_seen("R3 n=2 7-cycle pulse ignored", 8'hFF, 7, 20, 8'h00);
        @(negedge clk); pin_in = 8'hFF;
        idle(40); chk("R3 n=2 held level accepted", pin_out, 8'hFF);
        pin_in = '0;
        idle(40); chk("R3 n=2 return low", pin_out, 8'h00);
    endtask

    task automatic t_period_one;
        wr(1'b1, 16'hAAAA);
        wr(1'b0, 16'h0001);
        idle(20);
        pulse_seen("R3 R6 n=1 9-cycle pulse ignored", 8'hFF, 9, 20, 8'h00);
        @(negedge clk); pin_in = 8'hFF;
        idle(30); chk("R3 n=1 held level accepted", pin_out, 8'hFF);
        pin_in = '0; idle(30);
    endtask

    task automatic t_reload;
        wr(1'b1, 16'h5555);
        wr(1'b0, 16'h0040);
        idle(37);
        wr(1'b0, 16'h00FF);
        pin_in = 8'hFF;
        idle(1530); chk("R4 no third strobe yet", pin_out, 8'h00);
        idle(1);    chk("R4 third strobe after restart", pin_out, 8'hFF);
        wr(1'b0, 16'h0000);
        pin_in = '0; idle(12);
        chk("R9 period back to zero", pin_out, 8'h00);
    endtask

    initial begin
        idle(3);
        @(negedge clk); rst = 1'b0;
        t_reset();
        t_sync_follow();
        wr(1'b0, 16'h0000);
        t_three_latency();
        t_three_glitch();
        t_six();
        t_mixed();
        t_period_two();
        t_period_one();
        t_reload();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(4 * 100000);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule